// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block runs on the pixel clock and produces raster timing. A pixel counter steps across each line. A second counter tracks the frame in half-lines, so the top and bottom fields of an interlaced picture are handled natively. From these two counts the block decodes four independent horizontal/vertical sync pairs and an active-video window. It also drives a field flag and single-cycle pulses that mark the start of each field.

Software programs the block through a write-only port made of an address, a 32-bit data word and a strobe. Every timing value waits in a staging register and is copied to the working copy only when a frame starts or the counters restart, so a frame never mixes old and new settings. In master mode the counters run freely. In slave mode a rising edge on the external sync input restarts them.

Top module: `video_timing_core`

## Requirements
- R1: The pixel counter runs from 0 to line length minus 1 (register address 1, bits 15:0), then wraps to 0 and the line advances. A frame therefore lasts line length times line count cycles.
- R2: The frame length (address 2) is given in half-lines and is programmed as twice the line count. The half-line count advances by 2 per line. `field` is high while that count is at or above half the frame length (bottom field) and low otherwise (top field).
- R3: A position word carries a line number in bits 31:16 and a pixel number in bits 15:0. Line numbers start at 1 and pixel numbers start at 0.
- R4: `active` is high when the line lies in [start line, stop line) and the pixel lies in [start pixel, stop pixel). The window uses the top-field start/stop words (addresses 4 and 5) in the top field and the bottom-field words (addresses 6 and 7) in the bottom field.
- R5: For sync set s, the horizontal word at address 16+8s holds the rising pixel in bits 15:0 and the falling pixel in bits 31:16. `hsync[s]` is high for pixels in [rise, fall).
- R6: Set s has two vertical words: top field at 16+8s+1 and bottom field at 16+8s+2, each with start line in bits 15:0 and end line in bits 31:16. It also has two edge-pixel words: top at 16+8s+3 and bottom at 16+8s+4, with the start pixel in bits 15:0 and the end pixel in bits 31:16. `vsync[s]` is high from position (start line, start pixel) up to, but not including, (end line, end pixel).
- R7: A horizontal word whose rise and fall are equal (including all zero) holds `hsync` low. Equal vertical start and end lines hold `vsync` low in that field.
- R8: `top_start` pulses for one cycle when the frame begins at line 1, pixel 0. `bot_start` pulses for one cycle at pixel 0 of the first line of the bottom field. The two never coincide.
- R9: Writing a word with bit 0 set to address 3 puts the counters at line 1, pixel 0 on the next clock, and normal counting resumes after that.
- R10: Timing words written mid-frame have no effect until the next frame start or restart.
- R11: The mode word (address 0, bit 0) selects the source of restarts. A value of 0 is master mode, where `ext_sync` is ignored. A value of 1 is slave mode, where each rising edge of `ext_sync` restarts the counters like R9.
- R12: During reset all outputs are low. After reset the counters start at line 1, pixel 0, using the default line and frame lengths and all-zero sync and window words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| ext_sync | input | 1 | External sync, used in slave mode (synchronous to clk) |
| hsync | output | NSETS | Horizontal sync per set |
| vsync | output | NSETS | Vertical sync per set |
| active | output | 1 | Active-video window |
| field | output | 1 | High in the bottom field |
| top_start | output | 1 | One-cycle top-field start pulse |
| bot_start | output | 1 | One-cycle bottom-field start pulse |

## Verification
The bench sweeps every pixel of two whole frames of a 12-pixel, 6-line raster, with four deliberately different sync sets and a window that differs per field.

- An off-by-one in the wrap or in the half-open comparisons shows up as a sync edge or window edge one pixel off.
- A design that compared the vertical line alone would ignore the edge-pixel words and start `vsync` at pixel 0.
- Settings written mid-frame are tracked through the period between `top_start` pulses. A design without the staging copy would shorten the frame that is already under way.
- Slave restarts are checked against a level that is held for several cycles. A design that restarted on the level instead of the edge would keep the counters stuck at the frame start.

// File: rtl/video_timing_pkg.sv
package video_timing_pkg;
  localparam int POS_W       = 16;
  localparam int ADR_MODE    = 0;
  localparam int ADR_LLEN    = 1;
  localparam int ADR_FLEN    = 2;
  localparam int ADR_RESTART = 3;
  localparam int ADR_WIN     = 4;
  localparam int SYNC_BASE   = 16;
  localparam int SYNC_STRIDE = 8;

  typedef logic [31:0] word_t;

  typedef struct packed {
    word_t horiz;
    word_t vert_top;
    word_t vert_bot;
    word_t edge_top;
    word_t edge_bot;
  } sync_cfg_t;

  typedef struct packed {
    word_t top_start;
    word_t top_stop;
    word_t bot_start;
    word_t bot_stop;
  } win_cfg_t;

  // (line, pixel) has reached a packed position mark: one 32-bit compare
  function automatic logic pos_reached(logic [POS_W-1:0] ln, logic [POS_W-1:0] px,
                                       word_t mark);
    return {ln, px} >= mark;
  endfunction

  function automatic logic in_span(logic [POS_W-1:0] v, logic [POS_W-1:0] lo,
                                   logic [POS_W-1:0] hi);
    return (v >= lo) && (v < hi);
  endfunction
endpackage

// File: rtl/vt_regs.sv
module vt_regs
  import video_timing_pkg::*;
#(
  parameter int NSETS        = 4,
  parameter int ADDR_W       = 8,
  parameter int RST_LINE_LEN = 800,
  parameter int RST_FRAME_HL = 1050
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  word_t             wr_data,
  input  logic              load,
  output logic              slave_mode,
  output logic              restart_req,
  output logic [POS_W-1:0]  line_len,
  output logic [POS_W-1:0]  frame_hl,
  output win_cfg_t          win,
  output sync_cfg_t         sync_cfg [NSETS]
);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(ADR_MODE);
  localparam logic [ADDR_W-1:0] A_LLEN = ADDR_W'(ADR_LLEN);
  localparam logic [ADDR_W-1:0] A_FLEN = ADDR_W'(ADR_FLEN);
  localparam logic [ADDR_W-1:0] A_RST  = ADDR_W'(ADR_RESTART);
  localparam logic [ADDR_W-1:0] A_WIN  = ADDR_W'(ADR_WIN);

  logic             mode_q;
  logic [POS_W-1:0] llen_w, flen_w, llen_s, flen_s;
  win_cfg_t         win_w, win_s;

  assign restart_req = wr_en && (wr_addr == A_RST) && wr_data[0];
  assign slave_mode  = mode_q;
  assign line_len    = llen_s;
  assign frame_hl    = flen_s;
  assign win         = win_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      llen_w <= POS_W'(RST_LINE_LEN);
      flen_w <= POS_W'(RST_FRAME_HL);
      win_w  <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_MODE)               mode_q          <= wr_data[0];
      if (wr_addr == A_LLEN)               llen_w          <= wr_data[POS_W-1:0];
      if (wr_addr == A_FLEN)               flen_w          <= wr_data[POS_W-1:0];
      if (wr_addr == A_WIN)                win_w.top_start <= wr_data;
      if (wr_addr == A_WIN + ADDR_W'(1))   win_w.top_stop  <= wr_data;
      if (wr_addr == A_WIN + ADDR_W'(2))   win_w.bot_start <= wr_data;
      if (wr_addr == A_WIN + ADDR_W'(3))   win_w.bot_stop  <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      llen_s <= POS_W'(RST_LINE_LEN);
      flen_s <= POS_W'(RST_FRAME_HL);
      win_s  <= '0;
    end else if (load) begin
      llen_s <= llen_w;
      flen_s <= flen_w;
      win_s  <= win_w;
    end
  end

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    localparam logic [ADDR_W-1:0] B = ADDR_W'(SYNC_BASE + s * SYNC_STRIDE);
    sync_cfg_t stage_q, shadow_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= '0;
      else if (wr_en) begin
        if (wr_addr == B)               stage_q.horiz    <= wr_data;
        if (wr_addr == B + ADDR_W'(1))  stage_q.vert_top <= wr_data;
        if (wr_addr == B + ADDR_W'(2))  stage_q.vert_bot <= wr_data;
        if (wr_addr == B + ADDR_W'(3))  stage_q.edge_top <= wr_data;
        if (wr_addr == B + ADDR_W'(4))  stage_q.edge_bot <= wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    shadow_q <= '0;
      else if (load) shadow_q <= stage_q;
    end

    assign sync_cfg[s] = shadow_q;
  end

  // R10: working copy moves only on a frame start or restart
  p_shadow_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(line_len) && $stable(frame_hl) && $stable(win)));
endmodule

// File: rtl/vt_counter.sv
module vt_counter
  import video_timing_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] line_len,
  input  logic [POS_W-1:0] frame_hl,
  input  logic             restart_req,
  input  logic             slave_mode,
  input  logic             ext_sync,
  output logic [POS_W-1:0] px,
  output logic [POS_W-1:0] line_no,
  output logic             field_now,
  output logic             at_top,
  output logic             at_bot,
  output logic             load
);
  logic [POS_W-1:0] px_q, hl_q, half;
  logic ext_q, ext_rise, restart, line_end, frame_end;

  assign ext_rise  = slave_mode && ext_sync && !ext_q;
  assign restart   = restart_req || ext_rise;
  assign line_end  = ({1'b0, px_q} + 17'd1) >= {1'b0, line_len};
  assign frame_end = line_end && (({1'b0, hl_q} + 17'd2) >= {1'b0, frame_hl});
  assign load      = restart || frame_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      px_q  <= '0;
      hl_q  <= '0;
      ext_q <= 1'b0;
    end else begin
      ext_q <= ext_sync;
      if (restart) begin
        px_q <= '0;
        hl_q <= '0;
      end else if (line_end) begin
        px_q <= '0;
        hl_q <= frame_end ? '0 : hl_q + POS_W'(2);
      end else begin
        px_q <= px_q + POS_W'(1);
      end
    end
  end

  assign half      = frame_hl >> 1;
  assign px        = px_q;
  assign line_no   = {1'b0, hl_q[POS_W-1:1]} + POS_W'(1);
  assign field_now = hl_q >= half;
  assign at_top    = (px_q == '0) && (hl_q == '0);
  assign at_bot    = (px_q == '0) && field_now && ({1'b0, hl_q} < ({1'b0, half} + 17'd2));

  // R1: pixel count stays inside the programmed line
  p_pixel_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (line_len != '0) |-> (px_q < line_len));
  // R2: half-line count steps by two per line
  p_half_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && line_end && !frame_end) |=> (hl_q == $past(hl_q) + POS_W'(2)));
  // R9: restart lands on the frame origin
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (px_q == '0 && hl_q == '0));
  // R11: in master mode the external input never disturbs counting
  p_master_free_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && !restart_req && !line_end) |=> (px_q == $past(px_q) + POS_W'(1)));
endmodule

// File: rtl/vt_sync_set.sv
module vt_sync_set
  import video_timing_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  sync_cfg_t        cfg,
  input  logic [POS_W-1:0] px,
  input  logic [POS_W-1:0] line_no,
  input  logic             field_now,
  output logic             hs,
  output logic             vs
);
  word_t vert, edg;
  logic  h_on, v_on;

  assign vert = field_now ? cfg.vert_bot : cfg.vert_top;
  assign edg  = field_now ? cfg.edge_bot : cfg.edge_top;
  assign h_on = in_span(px, cfg.horiz[15:0], cfg.horiz[31:16]);
  assign v_on = (vert[15:0] != vert[31:16])
             && pos_reached(line_no, px, {vert[15:0], edg[15:0]})
             && !pos_reached(line_no, px, {vert[31:16], edg[31:16]});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs <= 1'b0;
      vs <= 1'b0;
    end else begin
      hs <= h_on;
      vs <= v_on;
    end
  end

  // R7: degenerate edge pairs keep the outputs idle
  p_h_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.horiz[15:0] == cfg.horiz[31:16]) |=> !hs);
  p_v_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vert[15:0] == vert[31:16]) |=> !vs);
endmodule

// File: rtl/vt_window.sv
module vt_window
  import video_timing_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  win_cfg_t         cfg,
  input  logic [POS_W-1:0] px,
  input  logic [POS_W-1:0] line_no,
  input  logic             field_now,
  output logic             act
);
  word_t from, upto;
  logic  act_on;

  assign from   = field_now ? cfg.bot_start : cfg.top_start;
  assign upto   = field_now ? cfg.bot_stop  : cfg.top_stop;
  assign act_on = in_span(line_no, from[31:16], upto[31:16])
               && in_span(px, from[15:0], upto[15:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act <= 1'b0;
    else        act <= act_on;
  end

  // R4: an empty line span never opens the window
  p_win_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upto[31:16] <= from[31:16]) |=> !act);
endmodule

// File: rtl/video_timing_core.sv
module video_timing_core
  import video_timing_pkg::*;
#(
  parameter int NSETS        = 4,
  parameter int ADDR_W       = 8,
  parameter int RST_LINE_LEN = 800,
  parameter int RST_FRAME_HL = 1050
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              ext_sync,
  output logic [NSETS-1:0]  hsync,
  output logic [NSETS-1:0]  vsync,
  output logic              active,
  output logic              field,
  output logic              top_start,
  output logic              bot_start
);
  logic             slave_mode, restart_req, load;
  logic [POS_W-1:0] line_len, frame_hl, px, line_no;
  logic             field_now, at_top, at_bot;
  win_cfg_t         win;
  sync_cfg_t        sync_cfg [NSETS];

  vt_regs #(
    .NSETS(NSETS), .ADDR_W(ADDR_W),
    .RST_LINE_LEN(RST_LINE_LEN), .RST_FRAME_HL(RST_FRAME_HL)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
    .load(load), .slave_mode(slave_mode), .restart_req(restart_req),
    .line_len(line_len), .frame_hl(frame_hl), .win(win), .sync_cfg(sync_cfg)
  );

  vt_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .line_len(line_len), .frame_hl(frame_hl),
    .restart_req(restart_req), .slave_mode(slave_mode), .ext_sync(ext_sync),
    .px(px), .line_no(line_no), .field_now(field_now),
    .at_top(at_top), .at_bot(at_bot), .load(load)
  );

  for (genvar s = 0; s < NSETS; s++) begin : g_sync
    vt_sync_set u_set (
      .clk(clk), .rst_n(rst_n), .cfg(sync_cfg[s]), .px(px), .line_no(line_no),
      .field_now(field_now), .hs(hsync[s]), .vs(vsync[s])
    );
  end

  vt_window u_win (
    .clk(clk), .rst_n(rst_n), .cfg(win), .px(px), .line_no(line_no),
    .field_now(field_now), .act(active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field     <= 1'b0;
      top_start <= 1'b0;
      bot_start <= 1'b0;
    end else begin
      field     <= field_now;
      top_start <= at_top;
      bot_start <= at_bot;
    end
  end

  // R8: the field pulses are exclusive, and the bottom one lasts one cycle
  p_pulse_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({top_start, bot_start}));
  p_bot_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bot_start |=> !bot_start);
  // R2: each pulse agrees with the field flag
  p_bot_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bot_start |-> field);
  p_top_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
    top_start |-> !field);
endmodule

// File: tb/video_timing_core_test.sv
`timescale 1ns/1ps
module video_timing_core_test;
  localparam int NS = 4;
  localparam int L  = 12;
  localparam int V  = 6;
  localparam int F  = 2 * V;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, ext = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [NS-1:0] hsync, vsync;
  logic active, field, top_start, bot_start;

  int checks = 0, errors = 0;
  logic [31:0] hw [NS], vt [NS], vb [NS], et [NS], eb [NS];
  logic [31:0] w_ts, w_tp, w_bs, w_bp;

  video_timing_core #(.NSETS(NS)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(we), .cfg_addr(addr), .cfg_wdata(wdata),
    .ext_sync(ext), .hsync(hsync), .vsync(vsync), .active(active), .field(field),
    .top_start(top_start), .bot_start(bot_start)
  );

  always #2 clk = ~clk;

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic chk(bit ok, string tag, logic [31:0] got, logic [31:0] want);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, want, $time);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = 8'(a); wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  function automatic bit e_span(int v, int lo, int hi);
    return (v >= lo) && (v < hi);
  endfunction

  // expected vertical sync from per-field words (line numbers from 1)
  function automatic bit e_vs(int s, int line, int px);
    bit fld = (2 * (line - 1)) >= V;
    logic [31:0] vr = fld ? vb[s] : vt[s];
    logic [31:0] er = fld ? eb[s] : et[s];
    longint key = longint'(line) * 65536 + px;
    longint k0  = longint'(vr[15:0]) * 65536 + er[15:0];
    longint k1  = longint'(vr[31:16]) * 65536 + er[31:16];
    return (vr[15:0] != vr[31:16]) && key >= k0 && key < k1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int pulses [$];
    // R12: reset state
    repeat (3) @(negedge clk);
    chk({hsync, vsync, active, field, top_start, bot_start} == '0, "R12 outputs in reset",
        32'({hsync, vsync, active, field, top_start, bot_start}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(top_start === 1'b1 && field === 1'b0, "R12 frame origin after reset",
        {30'd0, top_start, field}, 32'h2);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(top_start === 1'b0, "R8 top pulse single", 32'(top_start), 0);
      chk(hsync == '0 && vsync == '0 && active == 1'b0, "R7 zero words idle",
          32'({hsync, vsync, active}), 0);
    end

    // small raster, four contrasting sync sets, field-specific window
    hw[0] = 32'h0005_0002; vt[0] = 32'h0003_0001; vb[0] = 32'h0006_0004;
    et[0] = 32'h0000_0004; eb[0] = 32'h0006_0000;
    hw[1] = 32'h0;         vt[1] = 32'h0002_0002; vb[1] = 32'h0005_0004;
    et[1] = 32'h0;         eb[1] = 32'h0;
    hw[2] = 32'h000C_0000; vt[2] = 32'h0003_0001; vb[2] = 32'h0006_0004;
    et[2] = 32'h0;         eb[2] = 32'h0003_0002;
    hw[3] = 32'h0008_0007; vt[3] = 32'h0003_0003; vb[3] = 32'h0;
    et[3] = 32'h0;         eb[3] = 32'h0;
    w_ts = 32'h0002_0003; w_tp = 32'h0004_0009; w_bs = 32'h0005_0001; w_bp = 32'h0007_000B;
    wr(1, L); wr(2, F);
    wr(4, w_ts); wr(5, w_tp); wr(6, w_bs); wr(7, w_bp);
    for (int s = 0; s < NS; s++) begin
      wr(16 + 8*s, hw[s]); wr(17 + 8*s, vt[s]); wr(18 + 8*s, vb[s]);
      wr(19 + 8*s, et[s]); wr(20 + 8*s, eb[s]);
    end
    wr(0, 0);
    wr(3, 1);

    // full sweep over two frames: sample j shows position j-1 (R1, R3, R9)
    for (int j = 1; j <= 2 * L * V; j++) begin
      int t, px, line, hl;
      logic [NS-1:0] eh, ev;
      bit fld, ea, etop, ebot;
      @(negedge clk);
      t = j - 1; px = t % L; line = (t / L) % V + 1; hl = 2 * (line - 1);
      fld = hl >= F / 2;
      for (int s = 0; s < NS; s++) begin
        eh[s] = e_span(px, hw[s][15:0], hw[s][31:16]);
        ev[s] = e_vs(s, line, px);
      end
      ea = fld ? (e_span(line, w_bs[31:16], w_bp[31:16]) && e_span(px, w_bs[15:0], w_bp[15:0]))
               : (e_span(line, w_ts[31:16], w_tp[31:16]) && e_span(px, w_ts[15:0], w_tp[15:0]));
      etop = (px == 0) && (line == 1);
      ebot = (px == 0) && fld && (hl < F / 2 + 2);
      chk(hsync === eh, "R5/R7 hsync sweep", 32'(hsync), 32'(eh));
      chk(vsync === ev, "R6/R7 vsync sweep", 32'(vsync), 32'(ev));
      chk(active === ea, "R4/R3 window sweep", 32'(active), 32'(ea));
      chk(field === fld, "R2 field flag", 32'(field), 32'(fld));
      chk({top_start, bot_start} === {etop, ebot}, "R8/R1 field pulses",
          32'({top_start, bot_start}), 32'({etop, ebot}));
    end

    // R11: master mode ignores ext_sync
    wr(3, 1);
    pulses.delete();
    for (int j = 1; j <= 80; j++) begin
      @(negedge clk);
      if (top_start) pulses.push_back(j);
      if (j == 20) ext = 1'b1;
      if (j == 30) ext = 1'b0;
    end
    chk(pulses.size() == 2 && pulses[1] == 1 + L*V, "R11 master ignores ext_sync",
        32'(pulses.size() > 1 ? pulses[1] : 0), 32'(1 + L*V));

    // R11: slave mode restarts on the rising edge only
    wr(0, 1); wr(3, 1);
    pulses.delete();
    for (int j = 1; j <= 100; j++) begin
      @(negedge clk);
      if (top_start) pulses.push_back(j);
      if (j == 20) ext = 1'b1;
      if (j == 25) ext = 1'b0;
    end
    chk(pulses.size() == 3 && pulses[1] == 22 && pulses[2] == 22 + L*V,
        "R11 slave restart on edge", 32'(pulses.size()), 3);

    // R10: mid-frame line length change waits for the next frame
    wr(0, 0); wr(3, 1);
    pulses.delete();
    for (int j = 1; j <= 140; j++) begin
      @(negedge clk);
      if (top_start) pulses.push_back(j);
      if (j == 10) begin we = 1'b1; addr = 8'd1; wdata = 32'd10; end
      if (j == 11) we = 1'b0;
    end
    chk(pulses.size() >= 2 && pulses[1] == 1 + L*V, "R10 old length kept this frame",
        32'(pulses.size() > 1 ? pulses[1] : 0), 32'(1 + L*V));
    chk(pulses.size() >= 3 && pulses[2] == 1 + L*V + 10*V, "R10 new length next frame",
        32'(pulses.size() > 2 ? pulses[2] : 0), 32'(1 + L*V + 10*V));

    // R9: restart mid-frame returns to the origin on the next clock
    repeat (17) @(negedge clk);
    wr(3, 1);
    @(negedge clk);
    chk(top_start === 1'b1, "R9 restart origin", 32'(top_start), 1);

    summary();
    $finish;
  end
endmodule